// File: doc/BRIEF.md
# Second-Aligned Periodic Pulse Generator

This block drives a small set of fixed-interval pulse trains from a nanosecond time counter. Each generator holds a nanosecond down-count. Every counter tick removes the tick period from the count. When the count falls to zero or below, the generator raises a one-cycle pulse and adds its 32-bit period back. Any remainder carries into the next interval, so the trains do not drift when a period is not a whole number of ticks.

The generators do not free-run out of reset. Software sets the start flag and programs the first alarm of the time counter to one tick period before a whole second. When that alarm hits, all generators launch together, and each one pulses on the very next tick, which is the second boundary. Later alarm hits re-align the running trains in the same way, unless re-alignment is disabled. Every pulse also raises a strobe in an event vector at the bit position that the event register decodes.

Top module: `sec_pulse_gen`

## Requirements
- R1: After reset, every pulse line and every event bit is low and no generator runs.
- R2: While the timer is active and the start flag is set, an alarm hit with the generators idle launches all generators together. The down-count is loaded with the tick period, and a tick in the alarm cycle is not counted. Each generator pulses in the cycle after the first tick that follows.
- R3: An alarm hit while the generators are idle and the start flag is clear has no effect. No pulse appears on later ticks.
- R4: On each tick, a running generator subtracts the tick period from its count. If the result is zero or below, it drives a one-cycle pulse in the next cycle and adds its period to the result. Otherwise it keeps the result. A period below the tick period gives a pulse on every tick.
- R5: With re-alignment disabled, an alarm hit while the generators run is ignored and the trains continue undisturbed.
- R6: With re-alignment enabled, an alarm hit while the generators run reloads every count with the tick period. A tick in that cycle is not counted, and the next tick gives a pulse.
- R7: A new period value takes effect only at a generator's next reload. The interval already being counted completes unchanged.
- R8: When the timer enable is low or soft reset is high, all generators go idle within one cycle with their outputs low. They stay idle until a new launch.
- R9: Generator k (k = 0, 1, 2) reports its pulse on event bit 7-k, in the same cycle as its pulse line. All other event bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Time counter advance strobe |
| tick_ns_i | input | TICK_W | Nanoseconds added per tick |
| alarm_hit_i | input | 1 | First alarm of the time counter has matched |
| timer_en_i | input | 1 | Timer enable control bit |
| soft_rst_i | input | 1 | Timer soft reset control bit |
| start_i | input | 1 | Start flag arming launch on the next alarm |
| realign_off_i | input | 1 | Re-alignment disable control bit |
| period_i | input | NUM_GEN*PER_W | Period per generator in ns, generator 0 in the low bits |
| pulse_o | output | NUM_GEN | One-cycle pulse per generator |
| evt_o | output | 8 | Event strobes, generator k on bit 7-k |

## Verification
On every cycle, the assertions check a set of rules: that the run state clears whenever the timer is off, that an idle generator set cannot start without the start flag, that a pulse only follows a tick, that an inactive timer leaves the pulse lines quiet, and that a launch loads the tick period. The exact phase of the pulse trains can only be shown by the bench's scenarios, which compare against an independently computed count model. These include the first pulse on the boundary tick, remainder carry, ignored or honoured re-alignment, and the deferred effect of a period change.

// File: rtl/spg_pkg.sv
package spg_pkg;
    localparam int EVT_W   = 8;
    localparam int EVT_TOP = 7;

    typedef struct packed {
        logic run;
    } ctrl_state_t;
endpackage

// File: rtl/spg_ctrl.sv
module spg_ctrl
    import spg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic timer_en_i,
    input  logic soft_rst_i,
    input  logic start_i,
    input  logic realign_off_i,
    input  logic alarm_hit_i,
    output logic active_o,
    output logic launch_o,
    output logic run_o
);
    ctrl_state_t st_d, st_q;

    always_comb begin
        active_o = timer_en_i && !soft_rst_i;
        launch_o = active_o && alarm_hit_i && (st_q.run ? !realign_off_i : start_i);
        st_d     = st_q;
        st_d.run = active_o && (st_q.run || launch_o);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q.run;

    p_idle_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!timer_en_i || soft_rst_i) |=> !run_o);

    p_no_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_o && !start_i) |=> !run_o);
endmodule

// File: rtl/spg_chan.sv
module spg_chan #(
    parameter int PER_W  = 32,
    parameter int TICK_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              launch_i,
    input  logic              run_i,
    input  logic              tick_i,
    input  logic [TICK_W-1:0] tick_ns_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              pulse_o
);
    localparam int CNT_W = PER_W + 2;

    typedef struct packed {
        logic signed [CNT_W-1:0] cnt;
        logic                    pulse;
    } chan_state_t;

    chan_state_t st_d, st_q;
    logic signed [CNT_W-1:0] step_s, per_s, rest_s;

    always_comb begin
        step_s    = CNT_W'($unsigned(tick_ns_i));
        per_s     = CNT_W'($unsigned(period_i));
        rest_s    = st_q.cnt - step_s;
        st_d      = st_q;
        st_d.pulse = 1'b0;
        if (!active_i) begin
            st_d.cnt = '0;
        end else if (launch_i) begin
            st_d.cnt = step_s;
        end else if (run_i && tick_i) begin
            if (rest_s <= 0) begin
                st_d.pulse = 1'b1;
                st_d.cnt   = rest_s + per_s;
            end else begin
                st_d.cnt   = rest_s;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    p_pulse_after_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> $past(tick_i));

    p_quiet_when_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !pulse_o);

    p_launch_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        launch_i |=> (st_q.cnt == CNT_W'($unsigned($past(tick_ns_i)))));
endmodule

// File: rtl/sec_pulse_gen.sv
module sec_pulse_gen
    import spg_pkg::*;
#(
    parameter int NUM_GEN = 3,
    parameter int PER_W   = 32,
    parameter int TICK_W  = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     tick_i,
    input  logic [TICK_W-1:0]        tick_ns_i,
    input  logic                     alarm_hit_i,
    input  logic                     timer_en_i,
    input  logic                     soft_rst_i,
    input  logic                     start_i,
    input  logic                     realign_off_i,
    input  logic [NUM_GEN*PER_W-1:0] period_i,
    output logic [NUM_GEN-1:0]       pulse_o,
    output logic [EVT_W-1:0]         evt_o
);
    logic active, launch, run;

    spg_ctrl u_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .timer_en_i    (timer_en_i),
        .soft_rst_i    (soft_rst_i),
        .start_i       (start_i),
        .realign_off_i (realign_off_i),
        .alarm_hit_i   (alarm_hit_i),
        .active_o      (active),
        .launch_o      (launch),
        .run_o         (run)
    );

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_chan
        spg_chan #(.PER_W(PER_W), .TICK_W(TICK_W)) u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .active_i  (active),
            .launch_i  (launch),
            .run_i     (run),
            .tick_i    (tick_i),
            .tick_ns_i (tick_ns_i),
            .period_i  (period_i[g*PER_W +: PER_W]),
            .pulse_o   (pulse_o[g])
        );
    end

    always_comb begin
        evt_o = '0;
        for (int k = 0; k < NUM_GEN; k++) evt_o[EVT_TOP-k] = pulse_o[k];
    end

    initial begin
        p_gen_count_r9: assert (NUM_GEN >= 1 && NUM_GEN <= 3);
    end
endmodule

// File: tb/tb_sec_pulse_gen.sv
module tb_sec_pulse_gen;
    localparam int NG = 3;
    localparam int PW = 32;
    localparam int TW = 10;

    logic clk = 0, rst_n = 0;
    logic tick = 0, alarm = 0, en = 0, srst = 0, start = 0, rdis = 0;
    logic [TW-1:0] tp = 10'd8;
    logic [NG*PW-1:0] per = '0;
    logic [NG-1:0] pulse;
    logic [7:0] evt;

    int total = 0, bad = 0;
    string req = "R1";

    bit m_run = 0;
    longint m_cnt [NG];
    logic [NG-1:0] m_pulse = '0;

    always #10 clk = ~clk;

    sec_pulse_gen #(.NUM_GEN(NG), .PER_W(PW), .TICK_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick), .tick_ns_i(tp),
        .alarm_hit_i(alarm), .timer_en_i(en), .soft_rst_i(srst),
        .start_i(start), .realign_off_i(rdis), .period_i(per),
        .pulse_o(pulse), .evt_o(evt));

    function automatic logic [7:0] evt_of(logic [NG-1:0] p);
        logic [7:0] e = '0;
        for (int k = 0; k < NG; k++) e[7-k] = p[k];
        return e;
    endfunction

    task automatic check(string r, logic [NG-1:0] gp, logic [NG-1:0] ep, logic [7:0] ge, logic [7:0] ee);
        total++;
        if (gp !== ep || ge !== ee) begin
            bad++;
            $display("FAIL %s pulse=%b exp=%b evt=%b exp=%b", r, gp, ep, ge, ee);
        end
    endtask

    task automatic model_step();
        bit act, lau;
        longint n;
        act = en && !srst;
        lau = act && alarm && (m_run ? !rdis : start);
        for (int k = 0; k < NG; k++) begin
            m_pulse[k] = 1'b0;
            if (!act) m_cnt[k] = 0;
            else if (lau) m_cnt[k] = longint'(tp);
            else if (m_run && tick) begin
                n = m_cnt[k] - longint'(tp);
                if (n <= 0) begin
                    m_pulse[k] = 1'b1;
                    m_cnt[k] = n + longint'(per[k*PW +: PW]);
                end else m_cnt[k] = n;
            end
        end
        m_run = act && (m_run || lau);
    endtask

    task automatic cyc(bit t, bit a);
        tick = t; alarm = a;
        @(posedge clk);
        #1 model_step();
        @(negedge clk);
        check(req, pulse, m_pulse, evt, evt_of(m_pulse));
        tick = 0; alarm = 0;
    endtask

    task automatic set_per(int p0, int p1, int p2);
        per = {PW'(p2), PW'(p1), PW'(p0)};
    endtask

    initial begin
        #(200000 * 20);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        for (int k = 0; k < NG; k++) m_cnt[k] = 0;
        repeat (3) @(negedge clk);
        req = "R1";
        check("R1", pulse, '0, evt, 8'h00);
        rst_n = 1;
        cyc(1, 0);
        check("R1", pulse, '0, evt, 8'h00);

        // R3: alarm without start flag
        en = 1; set_per(32, 16, 48); req = "R3";
        cyc(0, 1);
        for (int i = 0; i < 12; i++) cyc(1, 0);
        check("R3", pulse, '0, evt, 8'h00);

        // R2: launch, alarm-cycle tick not counted, first pulse on next tick
        start = 1; req = "R2";
        cyc(1, 1);
        check("R2", pulse, '0, evt, 8'h00);
        cyc(0, 0);
        cyc(1, 0);
        check("R2", pulse, 3'b111, evt, 8'b1110_0000);
        check("R9", pulse, m_pulse, evt, 8'b1110_0000);

        // R4: steady trains, with idle cycles between ticks
        req = "R4";
        for (int i = 0; i < 40; i++) cyc(i % 3 != 0, 0);

        // R5: re-alignment disabled
        rdis = 1; req = "R5";
        for (int i = 0; i < 3; i++) cyc(1, 0);
        cyc(0, 1);
        for (int i = 0; i < 20; i++) cyc(1, 0);

        // R6: re-alignment enabled restarts all
        rdis = 0; req = "R6";
        cyc(1, 0);
        cyc(1, 1);
        cyc(1, 0);
        check("R6", pulse, 3'b111, evt, 8'b1110_0000);
        for (int i = 0; i < 10; i++) cyc(1, 0);

        // R7: period change deferred to reload
        req = "R7";
        set_per(56, 24, 12);
        for (int i = 0; i < 30; i++) cyc(1, 0);

        // R4: remainder carry and period below tick period
        req = "R4";
        set_per(20, 3, 0);
        for (int i = 0; i < 30; i++) cyc(1, 0);
        check("R4", pulse, m_pulse, evt, evt_of(m_pulse));

        // R8: disable and soft reset
        req = "R8";
        en = 0;
        cyc(1, 0);
        check("R8", pulse, '0, evt, 8'h00);
        en = 1;
        for (int i = 0; i < 5; i++) cyc(1, 0);
        check("R8", pulse, '0, evt, 8'h00);
        cyc(0, 1);
        for (int i = 0; i < 6; i++) cyc(1, 0);
        srst = 1;
        cyc(1, 0);
        check("R8", pulse, '0, evt, 8'h00);
        srst = 0;
        for (int i = 0; i < 4; i++) cyc(1, 0);

        // random mix
        req = "R4";
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) tp = TW'(1 + $urandom % 16);
            if ($urandom % 80 == 0) set_per($urandom % 90, $urandom % 90, $urandom % 90);
            start = ($urandom % 4) != 0;
            rdis  = ($urandom % 2) != 0;
            en    = ($urandom % 200) != 0;
            srst  = ($urandom % 300) == 0;
            cyc(($urandom % 3) != 0, ($urandom % 40) == 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule